// File: doc/BRIEF.md
# Byte-Serial Single-Channel DMA Engine

This block copies a run of bytes from a source to a destination without help from the processor. Software writes a start address for each side, a byte count and a mode through a 32-bit register port, then sets the run bit. The engine moves one byte per pair of bus beats on a request/grant master port: first a read beat from the source, then a write beat carrying the same byte to the destination.

The two bits of the mode field choose, independently for each side, whether that side is memory or a peripheral. A memory side steps its address by one for each byte. A peripheral side keeps its address fixed and holds each beat back until that side's ready input is high. When the run ends, a status word gives the outcome: all bytes moved, a failed read, or a failed write. Each outcome also raises a pending interrupt bit. Each pending bit can be masked and is cleared by writing a 1 to it. Reading either address register while a transfer runs, or after it ends, returns the count of bytes delivered so far.

Top module: `byteDma`

## Requirements
- R1: Control register (word 0): bit 0 starts a run when written 1 while idle. Bits [2:1] are the mode: bit 2 set makes the source a peripheral and bit 1 set makes the destination a peripheral, so 00 = memory to memory, 01 = memory to peripheral, 10 = peripheral to memory and 11 = peripheral to peripheral. A read returns the mode in bits [2:1] and, in bit 0, whether a run is in progress.
- R2: Register word indices are 0 control, 1 source, 2 destination, 3 size, 4 status, 5 interrupt mask, 6 interrupt clear and 7 interrupt pending (byte offset = 4 x index). A read of word 1 or word 2 returns the number of bytes written so far, zero-extended.
- R3: Every byte is a read beat (memWe = 0) followed by a write beat (memWe = 1) that carries the byte just read. A memory-side address is its base plus the byte index.
- R4: A peripheral-side beat uses the base address for every byte. Its request does not rise until that side's ready input is high.
- R5: Once memReq is high, it stays high with memAddr, memWe and memWdata unchanged until the cycle in which memGnt is high.
- R6: Status bit 0 (complete) sets when the byte count reaches the size. A run started with size 0 sets complete at once and issues no bus beat. No request is made while the engine is idle.
- R7: memErr sampled with the grant of a read beat sets status bit 1. memErr sampled with the grant of a write beat sets status bit 2. In both cases the run stops and complete stays clear.
- R8: Starting a run clears the byte count and all status bits. At most one status bit is ever set.
- R9: Each status event sets the matching pending bit (same bit order as the status word). The bit holds until a 1 is written to that bit of word 6. An event in the same cycle as the clear wins.
- R10: irq is high exactly when some pending bit has its mask bit (word 5, same order) set.
- R11: Writing 0 to control bit 0 during a run stops it once the beat in flight is granted, or at once if no beat is outstanding. No status bit is set, and the count keeps the number of bytes delivered.
- R12: While a run is in progress, writes to the control, source, destination and size registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWordIdx | input | 3 | Register word index |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regWordIdx (combinational) |
| memReq | output | 1 | Bus beat request |
| memWe | output | 1 | Beat direction, 1 = write |
| memAddr | output | ADDR_W | Beat address |
| memWdata | output | 8 | Write beat data |
| memGnt | input | 1 | Beat accepted this cycle |
| memRdata | input | 8 | Read data, valid with memGnt |
| memErr | input | 1 | Error response, valid with memGnt |
| srcReady | input | 1 | Source peripheral has data |
| dstReady | input | 1 | Destination peripheral can accept data |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the engine with an 8-bit byte counter and the default 32-bit address. It then sweeps all four modes against every size from 0 to 5 and two grant latencies, so every address stepping and fixing combination is covered, including the zero-length start. Its memory model returns a read byte computed from the address, so each delivered byte can be predicted by arithmetic. Extra runs inject a read or write error at a chosen byte, stop a slow run partway, and write registers during a run to show those writes are ignored.

// File: rtl/dmaPkg.sv
package dmaPkg;
  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_SRC  = 3'd1;
  localparam logic [2:0] REG_DST  = 3'd2;
  localparam logic [2:0] REG_SIZE = 3'd3;
  localparam logic [2:0] REG_STAT = 3'd4;
  localparam logic [2:0] REG_IEN  = 3'd5;
  localparam logic [2:0] REG_ICLR = 3'd6;
  localparam logic [2:0] REG_IPND = 3'd7;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} seqState_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic clrCount;
    logic incCount;
    logic grabByte;
    logic srcPeriph;
    logic dstPeriph;
    logic selWrite;
  } dpStrobe_t;
endpackage

// File: rtl/dmaDatapath.sv
module dmaDatapath
  import dmaPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [2:0]        cfgIdx,
  input  logic [ADDR_W-1:0] cfgData,
  input  dpStrobe_t         stb,
  input  logic [7:0]        memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic [CNT_W-1:0]  byteCount,
  output logic [CNT_W-1:0]  sizeVal,
  output logic [ADDR_W-1:0] srcBase,
  output logic [ADDR_W-1:0] dstBase,
  output logic              sizeZero,
  output logic              lastByte
);
  logic [7:0] dataHold;
  logic [ADDR_W-1:0] countExt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcBase   <= '0;
      dstBase   <= '0;
      sizeVal   <= '0;
      byteCount <= '0;
      dataHold  <= '0;
    end else begin
      if (cfgWrEn) begin
        case (cfgIdx)
          REG_SRC:  srcBase <= cfgData;
          REG_DST:  dstBase <= cfgData;
          REG_SIZE: sizeVal <= cfgData[CNT_W-1:0];
          default: ;
        endcase
      end
      if (stb.clrCount)      byteCount <= '0;
      else if (stb.incCount) byteCount <= byteCount + CNT_W'(1);
      if (stb.grabByte) dataHold <= memRdata;
    end
  end

  assign countExt = ADDR_W'(byteCount);
  assign memAddr  = stb.selWrite ? (dstBase + (stb.dstPeriph ? '0 : countExt))
                                 : (srcBase + (stb.srcPeriph ? '0 : countExt));
  assign memWdata = dataHold;
  assign sizeZero = (sizeVal == '0);
  assign lastByte = ((byteCount + CNT_W'(1)) == sizeVal);
endmodule

// File: rtl/dmaControl.sv
module dmaControl
  import dmaPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [2:0] regWordIdx,
  input  logic [2:0] ctrlData,
  input  logic       memGnt,
  input  logic       memErr,
  input  logic       srcReady,
  input  logic       dstReady,
  input  logic       sizeZero,
  input  logic       lastByte,
  output dpStrobe_t  stb,
  output logic       cfgWrEn,
  output logic       memReq,
  output logic       memWe,
  output logic       running,
  output logic [1:0] mode,
  output logic       issued,
  output logic [2:0] statBits,
  output logic [2:0] evtBits,
  output logic [2:0] intEn,
  output logic [2:0] intPend,
  output logic       irq
);
  seqState_t state, stateNext;
  logic abortFlag, startReq, stopReq, wrCtrl, sideReady, beatDone, abortNow, goIdle;
  logic [2:0] clrBits;

  assign running   = (state != ST_IDLE);
  assign wrCtrl    = regWrEn && (regWordIdx == REG_CTRL);
  assign startReq  = wrCtrl && ctrlData[0] && !running;
  assign stopReq   = wrCtrl && !ctrlData[0] && running;
  assign cfgWrEn   = regWrEn && !running;
  assign memWe     = (state == ST_WRITE);
  assign sideReady = memWe ? (!mode[0] || dstReady) : (!mode[1] || srcReady);
  assign abortNow  = running && abortFlag && !issued;
  assign memReq    = running && !abortNow && (issued || sideReady);
  assign beatDone  = memReq && memGnt;
  assign clrBits   = (regWrEn && regWordIdx == REG_ICLR) ? ctrlData : 3'b000;

  always_comb begin
    stateNext = state;
    evtBits   = 3'b000;
    case (state)
      ST_IDLE: if (startReq) begin
        if (sizeZero) evtBits[0] = 1'b1;
        else          stateNext  = ST_READ;
      end
      ST_READ: if (abortNow) stateNext = ST_IDLE;
        else if (beatDone) begin
          if (memErr) begin evtBits[1] = 1'b1; stateNext = ST_IDLE; end
          else if (abortFlag) stateNext = ST_IDLE;
          else stateNext = ST_WRITE;
        end
      ST_WRITE: if (abortNow) stateNext = ST_IDLE;
        else if (beatDone) begin
          if (memErr) begin evtBits[2] = 1'b1; stateNext = ST_IDLE; end
          else if (lastByte) begin evtBits[0] = 1'b1; stateNext = ST_IDLE; end
          else if (abortFlag) stateNext = ST_IDLE;
          else stateNext = ST_READ;
        end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign goIdle = running && (stateNext == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      mode      <= 2'b00;
      issued    <= 1'b0;
      abortFlag <= 1'b0;
      statBits  <= 3'b000;
      intEn     <= 3'b000;
      intPend   <= 3'b000;
    end else begin
      state     <= stateNext;
      issued    <= memReq && !memGnt;
      abortFlag <= (abortFlag || stopReq) && !goIdle;
      if (startReq) begin
        mode     <= ctrlData[2:1];
        statBits <= evtBits;
      end else begin
        statBits <= statBits | evtBits;
      end
      if (regWrEn && regWordIdx == REG_IEN) intEn <= ctrlData;
      intPend <= (intPend & ~clrBits) | evtBits;
    end
  end

  assign irq = |(intPend & intEn);

  always_comb begin
    stb.clrCount  = startReq;
    stb.incCount  = (state == ST_WRITE) && beatDone && !memErr;
    stb.grabByte  = (state == ST_READ) && beatDone;
    stb.srcPeriph = mode[1];
    stb.dstPeriph = mode[0];
    stb.selWrite  = memWe;
  end
endmodule

// File: rtl/byteDma.sv
module byteDma
  import dmaPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regWordIdx,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  input  logic              memGnt,
  input  logic [7:0]        memRdata,
  input  logic              memErr,
  input  logic              srcReady,
  input  logic              dstReady,
  output logic              irq
);
  localparam int CFG_W = (ADDR_W < 32) ? ADDR_W : 32;

  dpStrobe_t stb;
  logic cfgWrEn, running, issued, sizeZero, lastByte;
  logic [1:0] mode;
  logic [2:0] statBits, evtBits, intEn, intPend;
  logic [CNT_W-1:0] byteCount, sizeVal;
  logic [ADDR_W-1:0] srcBase, dstBase, cfgData;

  assign cfgData = ADDR_W'(regWdata[CFG_W-1:0]);

  dmaControl ctrl_i (
    .clk, .rstN, .regWrEn, .regWordIdx, .ctrlData(regWdata[2:0]),
    .memGnt, .memErr, .srcReady, .dstReady, .sizeZero, .lastByte,
    .stb, .cfgWrEn, .memReq, .memWe, .running, .mode, .issued,
    .statBits, .evtBits, .intEn, .intPend, .irq
  );

  dmaDatapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dp_i (
    .clk, .rstN, .cfgWrEn, .cfgIdx(regWordIdx), .cfgData, .stb, .memRdata,
    .memAddr, .memWdata, .byteCount, .sizeVal, .srcBase, .dstBase,
    .sizeZero, .lastByte
  );

  always_comb begin
    case (regWordIdx)
      REG_CTRL: regRdata = {29'd0, mode, running};
      REG_SRC,
      REG_DST:  regRdata = 32'(byteCount);
      REG_SIZE: regRdata = 32'(sizeVal);
      REG_STAT: regRdata = {29'd0, statBits};
      REG_IEN:  regRdata = {29'd0, intEn};
      REG_IPND: regRdata = {29'd0, intPend};
      default:  regRdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/byteDmaChecker.sv
module byteDmaChecker #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memGnt,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [7:0]        memWdata,
  input logic              srcReady,
  input logic              dstReady,
  input logic [1:0]        mode,
  input logic              issued,
  input logic              running,
  input logic [ADDR_W-1:0] srcBase,
  input logic [ADDR_W-1:0] dstBase,
  input logic [2:0]        statBits,
  input logic [2:0]        evtBits,
  input logic [2:0]        intPend,
  input logic [CNT_W-1:0]  byteCount,
  input logic [CNT_W-1:0]  sizeVal,
  input logic              regWrEn,
  input logic [2:0]        regWordIdx,
  input logic [2:0]        regWdata3
);
  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memGnt |=> memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata));

  assert_src_wait_R4: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memWe && mode[1] && !issued |-> srcReady);

  assert_dst_wait_R4: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe && mode[0] && !issued |-> dstReady);

  assert_src_fixed_R4: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memWe && mode[1] |-> memAddr == srcBase);

  assert_dst_fixed_R4: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe && mode[0] |-> memAddr == dstBase);

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> !memReq);

  assert_done_count_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statBits[0]) |-> byteCount == sizeVal);

  assert_status_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(statBits));

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regWordIdx == 3'd6 |=> (intPend & $past(regWdata3 & ~evtBits)) == 3'b000);

  assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    evtBits != 3'b000 |=> (intPend & $past(evtBits)) == $past(evtBits));
endmodule

bind byteDma byteDmaChecker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memGnt(memGnt), .memWe(memWe),
  .memAddr(memAddr), .memWdata(memWdata), .srcReady(srcReady), .dstReady(dstReady),
  .mode(mode), .issued(issued), .running(running), .srcBase(srcBase),
  .dstBase(dstBase), .statBits(statBits), .evtBits(evtBits), .intPend(intPend),
  .byteCount(byteCount), .sizeVal(sizeVal), .regWrEn(regWrEn),
  .regWordIdx(regWordIdx), .regWdata3(regWdata[2:0])
);

// File: tb/byteDma_tb_top.sv
module byteDma_tb_top;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [2:0] regWordIdx = 3'd0;
  logic [31:0] regWdata = 32'd0;
  logic [31:0] regRdata;
  logic memReq, memWe, irq;
  logic [ADDR_W-1:0] memAddr;
  logic [7:0] memWdata;
  logic memGnt = 1'b0, memErr = 1'b0;
  logic [7:0] memRdata = 8'd0;
  logic srcReady = 1'b0, dstReady = 1'b0;

  int checks = 0, errors = 0, cyc = 0, lat = 0, waitCnt = 0, runId = 0;
  logic [7:0] salt = 8'd0;
  logic errEn = 1'b0, errOnWrite = 1'b0;
  logic [7:0] errAddr = 8'd0;
  logic [7:0] wmem [0:255];
  int wtag [0:255];

  byteDma #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut_i (
    .clk, .rstN, .regWrEn, .regWordIdx, .regWdata, .regRdata,
    .memReq, .memWe, .memAddr, .memWdata, .memGnt, .memRdata, .memErr,
    .srcReady, .dstReady, .irq
  );

  always #5 clk = ~clk;

  function automatic logic [7:0] pattern(input logic [7:0] a);
    return 8'(a * 5) + salt;
  endfunction

  // Peripheral readiness changes just after each edge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    srcReady <= (cyc % 3) != 1;
    dstReady <= (cyc % 4) != 2;
    if (memReq && memGnt && memWe && !memErr) begin
      wmem[memAddr[7:0]] <= memWdata;
      wtag[memAddr[7:0]] <= runId;
    end
  end

  // Memory responder: grant after lat idle cycles
  always @(negedge clk) begin
    if (!rstN || memGnt) begin
      memGnt <= 1'b0; memErr <= 1'b0; waitCnt <= 0;
    end else if (memReq) begin
      if (waitCnt >= lat) begin
        memGnt   <= 1'b1;
        memRdata <= pattern(memAddr[7:0]);
        memErr   <= errEn && memAddr[7:0] == errAddr && memWe == errOnWrite;
      end else waitCnt <= waitCnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic regWr(input logic [2:0] idx, input logic [31:0] d);
    regWrEn = 1'b1; regWordIdx = idx; regWdata = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRd(input logic [2:0] idx, output logic [31:0] v);
    regWordIdx = idx;
    #1 v = regRdata;
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    for (int n = 0; n < 4000; n++) begin
      regRd(3'd0, v);
      if (v[0] == 1'b0) return;
      @(negedge clk);
    end
    chk("R6 run never ended", 32'd1, 32'd0);
  endtask

  task automatic startRun(input logic [1:0] m, input logic [7:0] s, input logic [7:0] d, input logic [7:0] n);
    runId++;
    salt = salt + 8'd37;
    regWr(3'd1, 32'(s));
    regWr(3'd2, 32'(d));
    regWr(3'd3, 32'(n));
    regWr(3'd0, {29'd0, m, 1'b1});
  endtask

  task automatic checkRun(input logic [1:0] m, input logic [7:0] s, input logic [7:0] d, input int n);
    logic [31:0] v;
    regRd(3'd4, v); chk("R6 complete status", v, 32'd1);
    regRd(3'd1, v); chk("R2 source word returns count", v, 32'(n));
    regRd(3'd2, v); chk("R2 destination word returns count", v, 32'(n));
    if (!m[0]) begin
      for (int i = 0; i < n; i++) begin
        chk("R3 byte written at stepped address", wtag[8'(d + i)], runId);
        chk(m[1] ? "R4 fixed source byte" : "R3 copied byte", 32'(wmem[8'(d + i)]),
            32'(pattern(m[1] ? s : 8'(s + i))));
      end
      chk("R3 no write past end", 32'(wtag[8'(d + n)] == runId), 32'd0);
    end else if (n == 0) begin
      chk("R6 size zero writes nothing", 32'(wtag[d] == runId), 32'd0);
    end else begin
      chk("R4 fixed destination written", wtag[d], runId);
      chk("R4 fixed destination holds last byte", 32'(wmem[d]),
          32'(pattern(m[1] ? s : 8'(s + n - 1))));
      chk("R4 nothing beyond fixed destination", 32'(wtag[8'(d + 1)] == runId), 32'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int c;
    for (int i = 0; i < 256; i++) begin wtag[i] = 0; wmem[i] = 8'd0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    regRd(3'd0, v); chk("R1 reset control", v, 32'd0);
    regRd(3'd4, v); chk("R8 reset status", v, 32'd0);
    regRd(3'd7, v); chk("R9 reset pending", v, 32'd0);
    chk("R10 reset irq", 32'(irq), 32'd0);

    // Sweep all modes, sizes 0..5, two latencies
    for (int l = 0; l < 2; l++) begin
      for (int m = 0; m < 4; m++) begin
        for (int n = 0; n < 6; n++) begin
          lat = l * 2;
          startRun(2'(m), 8'h10, 8'h40, 8'(n));
          waitIdle();
          checkRun(2'(m), 8'h10, 8'h40, n);
        end
      end
    end

    // R1: control readback during and after run
    lat = 3;
    startRun(2'b10, 8'h20, 8'h50, 8'd8);
    regRd(3'd0, v); chk("R1 control shows mode and run", v, 32'd5);
    waitIdle();
    regRd(3'd0, v); chk("R1 run bit clears at end", v, 32'd4);

    // R10/R9: masking and clearing
    regWr(3'd5, 32'd0);
    regWr(3'd6, 32'd7);
    lat = 0;
    startRun(2'b00, 8'h10, 8'h40, 8'd2);
    waitIdle();
    regRd(3'd7, v); chk("R9 pending set by complete", v, 32'd1);
    chk("R10 masked irq low", 32'(irq), 32'd0);
    regWr(3'd5, 32'd1);
    chk("R10 unmasked irq high", 32'(irq), 32'd1);
    regWr(3'd6, 32'd1);
    regRd(3'd7, v); chk("R9 pending cleared", v, 32'd0);
    chk("R10 irq low after clear", 32'(irq), 32'd0);

    // R7: read error at third byte
    regWr(3'd5, 32'd7);
    errEn = 1'b1; errOnWrite = 1'b0; errAddr = 8'h12;
    startRun(2'b00, 8'h10, 8'h40, 8'd4);
    waitIdle();
    regRd(3'd4, v); chk("R7 source error status", v, 32'd2);
    regRd(3'd1, v); chk("R7 count at read error", v, 32'd2);
    regRd(3'd7, v); chk("R9 source error pending", v, 32'd2);
    chk("R10 irq on source error", 32'(irq), 32'd1);
    regWr(3'd6, 32'd2);

    // R7: write error at second byte
    errOnWrite = 1'b1; errAddr = 8'h41;
    startRun(2'b00, 8'h10, 8'h40, 8'd4);
    waitIdle();
    regRd(3'd4, v); chk("R7 destination error status", v, 32'd4);
    regRd(3'd1, v); chk("R7 count at write error", v, 32'd1);
    regRd(3'd7, v); chk("R9 destination error pending", v, 32'd4);
    regWr(3'd6, 32'd4);
    errEn = 1'b0;

    // R8: restart clears error status
    startRun(2'b00, 8'h10, 8'h40, 8'd1);
    waitIdle();
    regRd(3'd4, v); chk("R8 restart clears status", v, 32'd1);
    regWr(3'd6, 32'd7);

    // R11: abort a slow run
    lat = 4;
    startRun(2'b00, 8'h10, 8'h70, 8'd12);
    repeat (25) @(negedge clk);
    regWr(3'd0, 32'd0);
    waitIdle();
    regRd(3'd4, v); chk("R11 abort sets no status", v, 32'd0);
    regRd(3'd1, v); c = int'(v);
    chk("R11 abort stopped early", 32'(c > 0 && c < 12), 32'd1);
    for (int i = 0; i < c; i++)
      chk("R11 delivered bytes intact", 32'(wmem[8'(8'h70 + i)]), 32'(pattern(8'(8'h10 + i))));
    chk("R11 no byte after stop", 32'(wtag[8'(8'h70 + c)] == runId), 32'd0);
    regRd(3'd7, v); chk("R11 no pending after abort", v, 32'd0);

    // R12: writes during a run are ignored
    lat = 2;
    startRun(2'b00, 8'h10, 8'h60, 8'd6);
    regWr(3'd2, 32'h90);
    regWr(3'd3, 32'd2);
    regWr(3'd0, 32'd7);
    waitIdle();
    checkRun(2'b00, 8'h10, 8'h60, 6);
    chk("R12 new destination unused", 32'(wtag[8'h90] == runId), 32'd0);
    regRd(3'd0, v); chk("R12 mode unchanged", v, 32'd0);
    regRd(3'd3, v); chk("R12 size unchanged", v, 32'd6);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule